// File: doc/BRIEF.md
# Ingress Rate Limiter with Frame Classification

This block meters the bytes a single port receives against a programmed byte budget. It keeps a byte token bucket that is topped up by a programmed amount on every rate tick, up to a burst ceiling. Each frame the port finishes receiving is reported by a one-cycle end strobe. The strobe carries the frame's byte length and three type flags: broadcast, multicast and flooded unicast. A two-bit mode code picks which of these frame classes are charged against the bucket. Frames outside the chosen classes pass untouched. Two configuration bits can add a fixed 12-byte gap overhead and a fixed 8-byte preamble overhead to each charged frame's length.

If a charged frame is longer than the tokens on hand, the port is over its rate. With the pause bit set, the block raises a flow-control request. That request is held until the bucket refills past half of its ceiling. With the pause bit clear, the block instead pulses a drop flag for that frame. A programmed rate of zero switches the limiter off.

Top module: `ingress_meter`

## Requirements
- R1: Limit mode 2'b00 charges every frame, whatever its type flags.
- R2: Limit mode 2'b01 charges frames flagged broadcast, multicast or flooded unicast; a frame with none of these flags neither touches the bucket nor is dropped.
- R3: Limit mode 2'b10 charges only frames flagged broadcast or multicast; flooded unicast frames are not charged.
- R4: Limit mode 2'b11 charges only frames flagged broadcast; multicast frames are not charged.
- R5: The charged length is the frame length plus 12 when the gap bit is 1, plus 8 when the preamble bit is 1.
- R6: Synchronous reset fills the bucket to the burst ceiling. Each rate tick adds the programmed rate, saturating at the ceiling.
- R7: A charged frame exceeds the rate when its charged length is strictly greater than the tokens held. An exceeding frame debits nothing; any other charged frame debits its charged length.
- R8: With the pause bit 1, an exceeding frame sets the flow-control request on the clock edge that ends the frame's strobe cycle, and no drop flag is raised.
- R9: With the pause bit 0, an exceeding frame raises the drop flag for exactly one cycle after its strobe cycle; the flow-control request stays low.
- R10: A raised flow-control request falls on the edge where the updated bucket level exceeds half the ceiling (rounded down), or the edge after the pause bit is seen at 0.
- R11: While the rate is 0, no frame is charged, nothing is dropped, and the flow-control request is low; the bucket level is kept.
- R12: Both outputs are registers and read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_end | input | 1 | One-cycle strobe: a frame has been received |
| frm_len | input | LEN_W | Byte length of that frame |
| frm_bcast | input | 1 | Frame is broadcast |
| frm_mcast | input | 1 | Frame is multicast |
| frm_flood | input | 1 | Frame is flooded unicast |
| cfg_mode | input | 2 | Limit mode code selecting charged classes |
| cfg_pause_en | input | 1 | 1: request flow control on excess; 0: drop |
| cfg_gap | input | 1 | Add 12 gap bytes to each charged length |
| cfg_pre | input | 1 | Add 8 preamble bytes to each charged length |
| cfg_rate | input | RATE_W | Bytes added per tick; 0 switches limiting off |
| cfg_burst | input | TOK_W | Bucket ceiling in bytes |
| rate_tick | input | 1 | Refill strobe |
| fc_req | output | 1 | Flow-control request |
| drop_flag | output | 1 | Pulse: the frame just ended is to be dropped |

## Verification
The bound checker watches, on every cycle, the properties that link outputs to their causes. A drop pulse must follow an ended frame in drop mode. A rising request must follow an ended frame in pause mode. Drop and request never coexist. A cleared pause bit or a zero rate silences the outputs. After any tick the bucket sits within its ceiling. Class selection per mode, the exact overhead byte counts, the strict greater-than boundary, saturation at the ceiling and the half-ceiling release point are shown only by the bench. Its scenarios drain the bucket to known levels and compare both outputs every clock against a behavioural reference.

// File: rtl/meter_pkg.sv
package meter_pkg;
  typedef enum logic [1:0] {
    LIM_ALL   = 2'b00,
    LIM_FLOOD = 2'b01,
    LIM_MULTI = 2'b10,
    LIM_BCAST = 2'b11
  } lim_mode_e;

  localparam int unsigned GAP_BYTES = 12;
  localparam int unsigned PRE_BYTES = 8;
endpackage

// File: rtl/meter_classify.sv
module meter_classify
  import meter_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       is_bc,
  input  logic       is_mc,
  input  logic       is_fl,
  output logic       charged
);
  lim_mode_e mode_e;
  assign mode_e = lim_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      LIM_ALL:   charged = 1'b1;
      LIM_FLOOD: charged = is_bc | is_mc | is_fl;
      LIM_MULTI: charged = is_bc | is_mc;
      LIM_BCAST: charged = is_bc;
      default:   charged = 1'b1;
    endcase
  end
endmodule

// File: rtl/meter_length.sv
module meter_length
  import meter_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int ADJ_W = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len,
  input  logic             add_gap,
  input  logic             add_pre,
  output logic [ADJ_W-1:0] adj_len
);
  logic [ADJ_W-1:0] gap_b, pre_b;
  assign gap_b   = add_gap ? ADJ_W'(GAP_BYTES) : '0;
  assign pre_b   = add_pre ? ADJ_W'(PRE_BYTES) : '0;
  assign adj_len = ADJ_W'(len) + gap_b + pre_b;
endmodule

// File: rtl/meter_bucket.sv
module meter_bucket #(
  parameter int TOK_W  = 24,
  parameter int ADJ_W  = 17,
  parameter int RATE_W = 16,
  localparam int SUM_W = TOK_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              charge,
  input  logic [ADJ_W-1:0]  adj_len,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  input  logic [TOK_W-1:0]  burst,
  output logic              exceed,
  output logic [TOK_W-1:0]  level,
  output logic [TOK_W-1:0]  level_nxt
);
  logic [TOK_W-1:0] level_q, adj_x, rate_x, after_debit;
  logic [SUM_W-1:0] refill_sum;

  assign adj_x  = TOK_W'(adj_len);
  assign rate_x = TOK_W'(rate);
  assign exceed = charge && (adj_x > level_q);

  always_comb begin
    after_debit = (charge && !exceed) ? (level_q - adj_x) : level_q;
    refill_sum  = SUM_W'(after_debit) + SUM_W'(rate_x);
    if (tick)
      level_nxt = (refill_sum > SUM_W'(burst)) ? burst : refill_sum[TOK_W-1:0];
    else
      level_nxt = after_debit;
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= burst;
    else     level_q <= level_nxt;
  end

  assign level = level_q;
endmodule

// File: rtl/meter_outreg.sv
module meter_outreg #(
  parameter int TOK_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exceed,
  input  logic             pause_en,
  input  logic             limit_on,
  input  logic [TOK_W-1:0] level_nxt,
  input  logic [TOK_W-1:0] burst,
  output logic             fc_req,
  output logic             drop_flag
);
  logic [TOK_W-1:0] half_b;
  logic             fc_q, drop_q;

  assign half_b = burst >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      fc_q   <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      drop_q <= exceed && !pause_en;
      if (!limit_on)
        fc_q <= 1'b0;
      else if (exceed && pause_en)
        fc_q <= 1'b1;
      else if (fc_q && (!pause_en || level_nxt > half_b))
        fc_q <= 1'b0;
    end
  end

  assign fc_req    = fc_q;
  assign drop_flag = drop_q;
endmodule

// File: rtl/ingress_meter.sv
module ingress_meter #(
  parameter int LEN_W  = 16,
  parameter int RATE_W = 16,
  parameter int TOK_W  = 24,
  localparam int ADJ_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_end,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              frm_bcast,
  input  logic              frm_mcast,
  input  logic              frm_flood,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_pause_en,
  input  logic              cfg_gap,
  input  logic              cfg_pre,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [TOK_W-1:0]  cfg_burst,
  input  logic              rate_tick,
  output logic              fc_req,
  output logic              drop_flag
);
  logic             cls_hit, limit_on, charge, exceed;
  logic [ADJ_W-1:0] adj_len;
  logic [TOK_W-1:0] tok_level, tok_next;

  assign limit_on = |cfg_rate;
  assign charge   = frm_end && cls_hit && limit_on;

  meter_classify u_cls (
    .mode(cfg_mode), .is_bc(frm_bcast), .is_mc(frm_mcast), .is_fl(frm_flood),
    .charged(cls_hit)
  );

  meter_length #(.LEN_W(LEN_W)) u_len (
    .len(frm_len), .add_gap(cfg_gap), .add_pre(cfg_pre), .adj_len(adj_len)
  );

  meter_bucket #(.TOK_W(TOK_W), .ADJ_W(ADJ_W), .RATE_W(RATE_W)) u_bkt (
    .clk(clk), .rst(rst), .charge(charge), .adj_len(adj_len),
    .tick(rate_tick), .rate(cfg_rate), .burst(cfg_burst),
    .exceed(exceed), .level(tok_level), .level_nxt(tok_next)
  );

  meter_outreg #(.TOK_W(TOK_W)) u_out (
    .clk(clk), .rst(rst), .exceed(exceed), .pause_en(cfg_pause_en),
    .limit_on(limit_on), .level_nxt(tok_next), .burst(cfg_burst),
    .fc_req(fc_req), .drop_flag(drop_flag)
  );
endmodule

// File: rtl/ingress_meter_chk.sv
module ingress_meter_chk #(
  parameter int RATE_W = 16,
  parameter int TOK_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_end,
  input logic              cfg_pause_en,
  input logic [RATE_W-1:0] cfg_rate,
  input logic [TOK_W-1:0]  cfg_burst,
  input logic              rate_tick,
  input logic [TOK_W-1:0]  tok_level,
  input logic              fc_req,
  input logic              drop_flag
);
  assert_drop_cause_R9: assert property (@(posedge clk) disable iff (rst)
    drop_flag |-> $past(frm_end && !cfg_pause_en && cfg_rate != '0));

  assert_drop_no_fc_R9: assert property (@(posedge clk) disable iff (rst)
    drop_flag |-> !fc_req);

  assert_fc_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fc_req) |-> $past(frm_end && cfg_pause_en));

  assert_fc_off_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_pause_en |=> !fc_req);

  assert_quiet_rate0_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_rate == '0 |=> (!drop_flag && !fc_req));

  assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
    rate_tick |=> tok_level <= $past(cfg_burst));
endmodule

bind ingress_meter ingress_meter_chk #(.RATE_W(RATE_W), .TOK_W(TOK_W)) u_chk (
  .clk(clk), .rst(rst), .frm_end(frm_end), .cfg_pause_en(cfg_pause_en),
  .cfg_rate(cfg_rate), .cfg_burst(cfg_burst), .rate_tick(rate_tick),
  .tok_level(tok_level), .fc_req(fc_req), .drop_flag(drop_flag)
);

// File: tb/sim_ingress_meter.sv
`timescale 1ns/1ps
module sim_ingress_meter;
  localparam int LEN_W = 16, RATE_W = 16, TOK_W = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic frm_end = 0, bc = 0, mc = 0, fl = 0;
  logic [LEN_W-1:0] frm_len = '0;
  logic [1:0] mode = 2'b00;
  logic pause_en = 0, gap = 0, pre = 0, tick = 0;
  logic [RATE_W-1:0] rate = 16'd100;
  logic [TOK_W-1:0]  burst = 24'd1000;
  logic fc_req, drop_flag;

  int n_cmp = 0, n_bad = 0;
  longint m_tok = 0;
  bit m_fc = 0, m_drop = 0;

  always #2.5 clk = ~clk;

  ingress_meter #(.LEN_W(LEN_W), .RATE_W(RATE_W), .TOK_W(TOK_W)) u0 (
    .clk(clk), .rst(rst), .frm_end(frm_end), .frm_len(frm_len),
    .frm_bcast(bc), .frm_mcast(mc), .frm_flood(fl), .cfg_mode(mode),
    .cfg_pause_en(pause_en), .cfg_gap(gap), .cfg_pre(pre), .cfg_rate(rate),
    .cfg_burst(burst), .rate_tick(tick), .fc_req(fc_req), .drop_flag(drop_flag)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit sel, exc;
    longint adj, nt;
    if (rst) begin
      m_tok = burst; m_fc = 0; m_drop = 0;
    end else begin
      case (mode)
        2'b00: sel = 1;
        2'b01: sel = bc || mc || fl;
        2'b10: sel = bc || mc;
        default: sel = bc;
      endcase
      sel = sel && frm_end && (rate != 0);
      adj = frm_len + (gap ? 12 : 0) + (pre ? 8 : 0);
      exc = sel && (adj > m_tok);
      nt  = (sel && !exc) ? m_tok - adj : m_tok;
      if (tick) begin
        nt = nt + rate;
        if (nt > burst) nt = burst;
      end
      m_drop = exc && !pause_en;
      if (rate == 0) m_fc = 0;
      else if (exc && pause_en) m_fc = 1;
      else if (m_fc && (!pause_en || nt > burst / 2)) m_fc = 0;
      m_tok = nt;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (fc_req !== m_fc || drop_flag !== m_drop) begin
        n_bad++;
        $display("FAIL R7-model fc_req=%0b drop=%0b expected fc_req=%0b drop=%0b",
                 fc_req, drop_flag, m_fc, m_drop);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send(input int len, input bit b, input bit m, input bit f);
    @(negedge clk);
    frm_len = LEN_W'(len); bc = b; mc = m; fl = f; frm_end = 1;
    @(negedge clk);
    frm_end = 0; bc = 0; mc = 0; fl = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 fc_req after reset", fc_req, 0);
    chk("R12 drop after reset", drop_flag, 0);

    // R1 / R7 / R9: bucket full at 1000
    send(600, 0, 0, 0); chk("R1 unicast 600 admitted", drop_flag, 0);
    send(500, 0, 0, 0); chk("R7 500>400 dropped", drop_flag, 1);
    chk("R9 no fc in drop mode", fc_req, 0);
    send(400, 0, 0, 0); chk("R7 equal length admitted", drop_flag, 0);
    // R6: refill and saturation
    ticks(5);
    send(500, 0, 0, 0); chk("R6 five ticks give 500", drop_flag, 0);
    ticks(20);
    send(1000, 0, 0, 0); chk("R6 refilled to ceiling", drop_flag, 0);
    send(1, 0, 0, 0); chk("R6 saturated at ceiling", drop_flag, 1);

    // R2: bucket empty
    mode = 2'b01;
    send(10, 0, 0, 0); chk("R2 plain unicast ignored", drop_flag, 0);
    send(10, 0, 0, 1); chk("R2 flooded charged", drop_flag, 1);
    ticks(1);
    send(100, 0, 1, 0); chk("R2 multicast fits", drop_flag, 0);
    // R3
    mode = 2'b10;
    send(10, 0, 0, 1); chk("R3 flooded ignored", drop_flag, 0);
    send(10, 0, 1, 0); chk("R3 multicast charged", drop_flag, 1);
    send(10, 1, 0, 0); chk("R3 broadcast charged", drop_flag, 1);
    // R4
    mode = 2'b11;
    send(10, 0, 1, 0); chk("R4 multicast ignored", drop_flag, 0);
    send(10, 1, 0, 0); chk("R4 broadcast charged", drop_flag, 1);

    // R5 overheads, mode 00
    mode = 2'b00;
    ticks(1); gap = 1;
    send(89, 0, 0, 0); chk("R5 gap 89+12>100", drop_flag, 1);
    send(88, 0, 0, 0); chk("R5 gap 88+12 fits", drop_flag, 0);
    ticks(1); gap = 0; pre = 1;
    send(93, 0, 0, 0); chk("R5 pre 93+8>100", drop_flag, 1);
    send(92, 0, 0, 0); chk("R5 pre 92+8 fits", drop_flag, 0);
    ticks(1); gap = 1;
    send(81, 0, 0, 0); chk("R5 both 81+20>100", drop_flag, 1);
    send(80, 0, 0, 0); chk("R5 both 80+20 fits", drop_flag, 0);
    gap = 0; pre = 0;

    // R8 / R10
    pause_en = 1;
    send(10, 0, 0, 0); chk("R8 fc raised", fc_req, 1);
    chk("R8 no drop in pause mode", drop_flag, 0);
    ticks(5); chk("R10 held at exactly half", fc_req, 1);
    ticks(1); chk("R10 released above half", fc_req, 0);
    send(700, 0, 0, 0); chk("R8 fc raised again", fc_req, 1);
    pause_en = 0;
    @(negedge clk); chk("R10 released by pause bit", fc_req, 0);

    // R11: bucket holds 600
    rate = '0;
    send(5000, 0, 0, 0); chk("R11 no drop at rate 0", drop_flag, 0);
    chk("R11 no fc at rate 0", fc_req, 0);
    rate = 16'd100;
    send(600, 0, 0, 0); chk("R11 bucket kept", drop_flag, 0);
    send(1, 0, 0, 0); chk("R11 bucket then empty", drop_flag, 1);

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule